// File: doc/BRIEF.md
# Compact-Opcode Instruction Decoder

This block is the decode and control stage of a small single-issue core whose instructions are 17 bits wide. It takes one instruction word and drives the datapath's control strobes: register-write enable, destination select, ALU-source select, a 3-bit ALU operation code, memory read and write enables, branch-on-equal and branch-on-not-equal flags, a jump-through-register flag and an illegal-opcode flag. It also splits out the three register specifiers and forms the immediate or offset value.

The 5-bit opcode alone names the operation, because there is no secondary function field. Loads and stores each own a block of four opcodes that share their upper three bits. The two low opcode bits of that block become the top bits of a 6-bit offset, so a memory offset can reach 47 rather than 15. The block is purely combinational. The ALU, register file, memories and program-counter update sit outside it.

The instruction layout is opcode[16:12], rs[11:8], rt[7:4], and rd or constant[3:0]. ALU operation codes are ADD=0, SUB=1, AND=2, OR=3, MUL=4, SLT=5, SLL=6 and SRL=7. The destination select is 1 for the rd field and 0 for the rt field.

Top module: `opdec_top`

## Requirements
- R1: For every word, rsAddr equals bits [11:8], rtAddr equals bits [7:4] and rdAddr equals bits [3:0].
- R2: Opcodes 0..5 (add, sub, and, or, mult, slt) set regWrite=1, dstSel=1, aluSrcImm=0, aluOp=0,1,2,3,4,5 respectively, with memory, branch, jump and illegal all 0.
- R3: Opcodes 6 (sll, aluOp 6) and 7 (srl, aluOp 7) set regWrite=1, dstSel=0, aluSrcImm=1, and immOut = bits [3:0] zero-extended.
- R4: Opcodes 8..11 (addi, andi, ori, slti) set regWrite=1, dstSel=0, aluSrcImm=1, aluOp=0,2,3,5, and immOut = bits [3:0] zero-extended (0..15).
- R5: Opcodes 16, 17 and 18 (load) set memRead=1, regWrite=1, dstSel=0, aluSrcImm=1, aluOp=0, and immOut = {opcode[1:0], bits[3:0]}, giving a range of 0..47.
- R6: Opcodes 20, 21 and 22 (store) set memWrite=1, regWrite=0, aluSrcImm=1, aluOp=0, and immOut is formed as in R5.
- R7: Opcode 12 sets brEq=1 and opcode 13 sets brNe=1. Both set aluOp=1, aluSrcImm=0 and regWrite=0, with immOut = bits [3:0] zero-extended.
- R8: Opcode 14 (jr) sets jumpReg=1 with regWrite, memRead, memWrite and both branch flags at 0.
- R9: Opcodes 15, 19, 23 and 24..31 set illegal=1 and clear regWrite, memRead, memWrite, brEq, brNe and jumpReg. Every other opcode has illegal=0.
- R10: The control outputs depend on the opcode alone. Changing bits [11:0] leaves every control output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 17 | Instruction word to decode |
| rsAddr | output | 4 | First source register specifier |
| rtAddr | output | 4 | Second source or immediate-destination specifier |
| rdAddr | output | 4 | Register-form destination specifier |
| immOut | output | 6 | Zero-extended constant, shift amount or offset |
| regWrite | output | 1 | Register file write enable |
| dstSel | output | 1 | 1 writes to rd, 0 writes to rt |
| aluSrcImm | output | 1 | 1 routes immOut to the ALU second operand |
| aluOp | output | 3 | ALU operation code |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| brEq | output | 1 | Branch when operands are equal |
| brNe | output | 1 | Branch when operands differ |
| jumpReg | output | 1 | Jump to the address held in rs |
| illegal | output | 1 | Opcode is unassigned |

## Verification
The hardest case to reach is the reserved top slot of each memory block (opcodes 19 and 23). A decoder that tests only the upper three opcode bits would treat these as valid loads or stores. The offset would then silently wrap past 47 with the memory enables still on.

The stimulus sweeps all 32 opcodes with several operand-field patterns. It also aims directly at the low-bit corners of each memory block with constant fields of 0 and 15. This exercises both offset extremes (0 and 47) and shows that the reserved slot drops every enable.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  parameter int INSTR_W = 17;
  parameter int OPC_W   = 5;
  parameter int REG_W   = 4;
  parameter int IMM_W   = 6;
  parameter int ALUOP_W = 3;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_MUL = 3'd4,
    ALU_SLT = 3'd5,
    ALU_SLL = 3'd6,
    ALU_SRL = 3'd7
  } aluOp_t;

  // Strobes passed from the control decoder to the field datapath and ports
  typedef struct packed {
    logic   regWrite;
    logic   dstSel;
    logic   aluSrcImm;
    aluOp_t aluOp;
    logic   memRead;
    logic   memWrite;
    logic   brEq;
    logic   brNe;
    logic   jumpReg;
    logic   illegal;
    logic   wideOffset;
  } ctrlStrobes_t;

  // Opcode assignments
  parameter logic [OPC_W-1:0] OP_ADD  = 5'd0;
  parameter logic [OPC_W-1:0] OP_SUB  = 5'd1;
  parameter logic [OPC_W-1:0] OP_AND  = 5'd2;
  parameter logic [OPC_W-1:0] OP_OR   = 5'd3;
  parameter logic [OPC_W-1:0] OP_MUL  = 5'd4;
  parameter logic [OPC_W-1:0] OP_SLT  = 5'd5;
  parameter logic [OPC_W-1:0] OP_SLL  = 5'd6;
  parameter logic [OPC_W-1:0] OP_SRL  = 5'd7;
  parameter logic [OPC_W-1:0] OP_ADDI = 5'd8;
  parameter logic [OPC_W-1:0] OP_ANDI = 5'd9;
  parameter logic [OPC_W-1:0] OP_ORI  = 5'd10;
  parameter logic [OPC_W-1:0] OP_SLTI = 5'd11;
  parameter logic [OPC_W-1:0] OP_BEQ  = 5'd12;
  parameter logic [OPC_W-1:0] OP_BNE  = 5'd13;
  parameter logic [OPC_W-1:0] OP_JR   = 5'd14;

  // Memory blocks: upper opcode bits shared, low bits feed the offset
  parameter int MEM_LO_W = IMM_W - REG_W;
  parameter int MEM_HI_W = OPC_W - MEM_LO_W;
  parameter logic [MEM_HI_W-1:0] MEMBLK_LOAD  = 3'b100;
  parameter logic [MEM_HI_W-1:0] MEMBLK_STORE = 3'b101;

endpackage

// File: rtl/opdec_ctrl.sv
module opdec_ctrl
  import opdec_pkg::*;
#(
  parameter int OpcW = OPC_W
) (
  input  logic [OpcW-1:0] opcode,
  output ctrlStrobes_t    strobes
);

  localparam int LoW = MEM_LO_W;
  localparam int HiW = OpcW - LoW;

  logic [HiW-1:0] blkSel;
  logic [LoW-1:0] blkSlot;
  logic           slotReserved;

  assign blkSel       = opcode[OpcW-1:LoW];
  assign blkSlot      = opcode[LoW-1:0];
  assign slotReserved = &blkSlot;

  always_comb begin
    strobes         = '0;
    strobes.aluOp   = ALU_ADD;
    strobes.illegal = 1'b0;
    if (blkSel == MEMBLK_LOAD) begin
      if (slotReserved) begin
        strobes.illegal = 1'b1;
      end else begin
        strobes.memRead    = 1'b1;
        strobes.regWrite   = 1'b1;
        strobes.aluSrcImm  = 1'b1;
        strobes.wideOffset = 1'b1;
      end
    end else if (blkSel == MEMBLK_STORE) begin
      if (slotReserved) begin
        strobes.illegal = 1'b1;
      end else begin
        strobes.memWrite   = 1'b1;
        strobes.aluSrcImm  = 1'b1;
        strobes.wideOffset = 1'b1;
      end
    end else begin
      unique case (opcode)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_MUL, OP_SLT: begin
          strobes.regWrite = 1'b1;
          strobes.dstSel   = 1'b1;
          unique case (opcode)
            OP_SUB:  strobes.aluOp = ALU_SUB;
            OP_AND:  strobes.aluOp = ALU_AND;
            OP_OR:   strobes.aluOp = ALU_OR;
            OP_MUL:  strobes.aluOp = ALU_MUL;
            OP_SLT:  strobes.aluOp = ALU_SLT;
            default: strobes.aluOp = ALU_ADD;
          endcase
        end
        OP_SLL, OP_SRL: begin
          strobes.regWrite  = 1'b1;
          strobes.aluSrcImm = 1'b1;
          strobes.aluOp     = (opcode == OP_SLL) ? ALU_SLL : ALU_SRL;
        end
        OP_ADDI, OP_ANDI, OP_ORI, OP_SLTI: begin
          strobes.regWrite  = 1'b1;
          strobes.aluSrcImm = 1'b1;
          unique case (opcode)
            OP_ANDI: strobes.aluOp = ALU_AND;
            OP_ORI:  strobes.aluOp = ALU_OR;
            OP_SLTI: strobes.aluOp = ALU_SLT;
            default: strobes.aluOp = ALU_ADD;
          endcase
        end
        OP_BEQ: begin
          strobes.brEq  = 1'b1;
          strobes.aluOp = ALU_SUB;
        end
        OP_BNE: begin
          strobes.brNe  = 1'b1;
          strobes.aluOp = ALU_SUB;
        end
        OP_JR: begin
          strobes.jumpReg = 1'b1;
        end
        default: begin
          strobes.illegal = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
#(
  parameter int RegW  = REG_W,
  parameter int ImmW  = IMM_W
) (
  input  logic [3*RegW-1:0]     operandBits,
  input  logic [ImmW-RegW-1:0]  opcodeLow,
  input  ctrlStrobes_t          strobes,
  output logic [RegW-1:0]       rsAddr,
  output logic [RegW-1:0]       rtAddr,
  output logic [RegW-1:0]       rdAddr,
  output logic [ImmW-1:0]       immOut
);

  localparam int ExtW = ImmW - RegW;

  logic [RegW-1:0] fieldSlice [3];

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_slice
      assign fieldSlice[g] = operandBits[g*RegW +: RegW];
    end
  endgenerate

  assign rsAddr = fieldSlice[2];
  assign rtAddr = fieldSlice[1];
  assign rdAddr = fieldSlice[0];

  always_comb begin
    if (strobes.wideOffset) begin
      immOut = {opcodeLow, fieldSlice[0]};
    end else begin
      immOut = {{ExtW{1'b0}}, fieldSlice[0]};
    end
  end

endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int InstrW = INSTR_W,
  parameter int OpcW   = OPC_W,
  parameter int RegW   = REG_W,
  parameter int ImmW   = IMM_W
) (
  input  logic [InstrW-1:0]  instrWord,
  output logic [RegW-1:0]    rsAddr,
  output logic [RegW-1:0]    rtAddr,
  output logic [RegW-1:0]    rdAddr,
  output logic [ImmW-1:0]    immOut,
  output logic               regWrite,
  output logic               dstSel,
  output logic               aluSrcImm,
  output logic [ALUOP_W-1:0] aluOp,
  output logic               memRead,
  output logic               memWrite,
  output logic               brEq,
  output logic               brNe,
  output logic               jumpReg,
  output logic               illegal
);

  localparam int OperW = InstrW - OpcW;
  localparam int LowW  = ImmW - RegW;

  ctrlStrobes_t strobes;

  opdec_ctrl #(.OpcW(OpcW)) u_ctrl (
    .opcode  (instrWord[InstrW-1:OperW]),
    .strobes (strobes)
  );

  opdec_fields #(.RegW(RegW), .ImmW(ImmW)) u_fields (
    .operandBits (instrWord[OperW-1:0]),
    .opcodeLow   (instrWord[OperW +: LowW]),
    .strobes     (strobes),
    .rsAddr      (rsAddr),
    .rtAddr      (rtAddr),
    .rdAddr      (rdAddr),
    .immOut      (immOut)
  );

  assign regWrite  = strobes.regWrite;
  assign dstSel    = strobes.dstSel;
  assign aluSrcImm = strobes.aluSrcImm;
  assign aluOp     = strobes.aluOp;
  assign memRead   = strobes.memRead;
  assign memWrite  = strobes.memWrite;
  assign brEq      = strobes.brEq;
  assign brNe      = strobes.brNe;
  assign jumpReg   = strobes.jumpReg;
  assign illegal   = strobes.illegal;

endmodule

// File: rtl/opdec_checker.sv
module opdec_checker
  import opdec_pkg::*;
(
  input logic [INSTR_W-1:0] instrWord,
  input logic [IMM_W-1:0]   immOut,
  input logic               regWrite,
  input logic               dstSel,
  input logic               aluSrcImm,
  input logic               memRead,
  input logic               memWrite,
  input logic               brEq,
  input logic               brNe,
  input logic               jumpReg,
  input logic               illegal
);

  localparam int OperW = INSTR_W - OPC_W;
  logic isMemBlk;
  assign isMemBlk = (instrWord[INSTR_W-1 -: 2] == 2'b10);

  always_comb begin
    // R9
    illegal_quiet_chk: assert (!illegal ||
      !(regWrite | memRead | memWrite | brEq | brNe | jumpReg));
    // R5
    mem_excl_chk: assert (!(memRead && memWrite));
    // R5
    offset_range_chk: assert (!(memRead || memWrite) || (immOut <= 6'd47));
    // R7
    flow_onehot_chk: assert ($onehot0({brEq, brNe, jumpReg, memRead, memWrite}));
    // R2
    rform_dest_chk: assert (!(regWrite && !aluSrcImm) || dstSel);
    // R9
    memslot_reserved_chk: assert (!(isMemBlk && (&instrWord[OperW +: 2])) || illegal);
  end

endmodule

bind opdec_top opdec_checker u_chk (
  .instrWord (instrWord),
  .immOut    (immOut),
  .regWrite  (regWrite),
  .dstSel    (dstSel),
  .aluSrcImm (aluSrcImm),
  .memRead   (memRead),
  .memWrite  (memWrite),
  .brEq      (brEq),
  .brNe      (brNe),
  .jumpReg   (jumpReg),
  .illegal   (illegal)
);

// File: tb/opdec_top_test.sv
module opdec_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] instrWord = '0;
  logic [3:0]  rsAddr, rtAddr, rdAddr;
  logic [5:0]  immOut;
  logic        regWrite, dstSel, aluSrcImm, memRead, memWrite;
  logic        brEq, brNe, jumpReg, illegal;
  logic [2:0]  aluOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opdec_top uut (
    .instrWord (instrWord), .rsAddr (rsAddr), .rtAddr (rtAddr), .rdAddr (rdAddr),
    .immOut (immOut), .regWrite (regWrite), .dstSel (dstSel), .aluSrcImm (aluSrcImm),
    .aluOp (aluOp), .memRead (memRead), .memWrite (memWrite), .brEq (brEq),
    .brNe (brNe), .jumpReg (jumpReg), .illegal (illegal)
  );

  // Packed control vector: regWrite,dstSel,aluSrcImm,aluOp[2:0],memRead,memWrite,brEq,brNe,jumpReg,illegal
  function automatic logic [11:0] expCtl(input int op);
    logic [11:0] v;
    v = '0;
    if (op <= 5)                     v = {1'b1, 1'b1, 1'b0, 3'(op), 6'b0};           // R2
    else if (op == 6)                v = {1'b1, 1'b0, 1'b1, 3'd6, 6'b0};             // R3
    else if (op == 7)                v = {1'b1, 1'b0, 1'b1, 3'd7, 6'b0};             // R3
    else if (op == 8)                v = {1'b1, 1'b0, 1'b1, 3'd0, 6'b0};             // R4
    else if (op == 9)                v = {1'b1, 1'b0, 1'b1, 3'd2, 6'b0};             // R4
    else if (op == 10)               v = {1'b1, 1'b0, 1'b1, 3'd3, 6'b0};             // R4
    else if (op == 11)               v = {1'b1, 1'b0, 1'b1, 3'd5, 6'b0};             // R4
    else if (op == 12)               v = {1'b0, 1'b0, 1'b0, 3'd1, 6'b001000};        // R7
    else if (op == 13)               v = {1'b0, 1'b0, 1'b0, 3'd1, 6'b000100};        // R7
    else if (op == 14)               v = {1'b0, 1'b0, 1'b0, 3'd0, 6'b000010};        // R8
    else if (op >= 16 && op <= 18)   v = {1'b1, 1'b0, 1'b1, 3'd0, 6'b100000};        // R5
    else if (op >= 20 && op <= 22)   v = {1'b0, 1'b0, 1'b1, 3'd0, 6'b010000};        // R6
    else                             v = {1'b0, 1'b0, 1'b0, 3'd0, 6'b000001};        // R9
    return v;
  endfunction

  function automatic logic [5:0] expImm(input int op, input logic [3:0] c);
    if ((op >= 16 && op <= 18) || (op >= 20 && op <= 22)) return {op[1:0], c};
    return {2'b00, c};
  endfunction

  function automatic string reqFor(input int op);
    if (op <= 5) return "R2";
    if (op <= 7) return "R3";
    if (op <= 11) return "R4";
    if (op <= 13) return "R7";
    if (op == 14) return "R8";
    if (op >= 16 && op <= 18) return "R5";
    if (op >= 20 && op <= 22) return "R6";
    return "R9";
  endfunction

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyWord(input int op, input logic [3:0] a, input logic [3:0] b,
                           input logic [3:0] c);
    @(posedge clk);
    instrWord = {5'(op), a, b, c};
    @(negedge clk);
    checkVal(reqFor(op), "ctrl", int'({regWrite, dstSel, aluSrcImm, aluOp, memRead,
             memWrite, brEq, brNe, jumpReg, illegal}), int'(expCtl(op)));
    checkVal(reqFor(op), "imm", int'(immOut), int'(expImm(op, c)));
    checkVal("R1", "fields", int'({rsAddr, rtAddr, rdAddr}), int'({a, b, c}));
  endtask

  task automatic testQuiescent();
    applyWord(0, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic testSweep();
    for (int op = 0; op < 32; op++) begin
      applyWord(op, 4'h3, 4'hA, 4'h5);
      applyWord(op, 4'hF, 4'h0, 4'hC);
    end
  endtask

  task automatic testOffsetCorners();
    for (int op = 16; op < 24; op++) begin
      applyWord(op, 4'h1, 4'h2, 4'h0);
      applyWord(op, 4'h1, 4'h2, 4'hF);
    end
    applyWord(22, 4'h0, 4'h0, 4'hF);
    checkVal("R6", "max offset 47", int'(immOut), 47);
    applyWord(18, 4'h0, 4'h0, 4'hF);
    checkVal("R5", "max offset 47", int'(immOut), 47);
    applyWord(19, 4'h0, 4'h0, 4'hF);
    checkVal("R9", "reserved load slot", int'(illegal), 1);
    applyWord(23, 4'h0, 4'h0, 4'hF);
    checkVal("R9", "reserved store slot", int'(memWrite), 0);
  endtask

  task automatic testOpcodeOnly();
    logic [11:0] ref0;
    for (int op = 0; op < 32; op++) begin
      applyWord(op, 4'h0, 4'h0, 4'h0);
      ref0 = {regWrite, dstSel, aluSrcImm, aluOp, memRead, memWrite, brEq, brNe, jumpReg, illegal};
      applyWord(op, 4'hF, 4'hF, 4'hF);
      checkVal("R10", "ctrl invariant", int'({regWrite, dstSel, aluSrcImm, aluOp, memRead,
               memWrite, brEq, brNe, jumpReg, illegal}), int'(ref0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testQuiescent();
    testSweep();
    testOffsetCorners();
    testOpcodeOnly();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule